// File: doc/BRIEF.md
# UART Channel Command Decoder

This block takes byte writes aimed at one serial channel's command register and turns them into control actions for that channel. One byte carries three independent fields: a 3-bit miscellaneous command code, a two-bit transmitter enable field and a two-bit receiver enable field. The most significant bit carries no meaning. The block holds the receiver and transmitter enable states and a pointer that selects which of two mode registers the next mode access targets. It also holds the eight channel status flags that commands can clear. It emits a one-cycle pulse that tells the receive FIFO to reinitialise its pointer.

The channel datapath reports status events through per-bit set and clear inputs. A write strobe with the data byte delivers commands. A separate strobe signals each access to a mode register. All results are registered and show one clock after the stimulus that causes them. The status byte is presented on a read port.

Top module: `uart_cmd_ctl`

## Requirements
- R1: After the synchronous active-high reset, rx_en, tx_en, mr_sel, rx_ptr_init and every status_o bit are 0.
- R2: cmd_data[7] has no effect. A byte that differs only in bit 7 yields identical outputs.
- R3: Code 001 in cmd_data[6:4] sets mr_sel to 0 (mode register one) on the next cycle. It wins over a mode access in the same cycle.
- R4: Code 010 clears rx_en, status_o[0] (receive ready) and status_o[1] (FIFO full), and pulses rx_ptr_init for exactly one cycle. No other output changes.
- R5: Code 011 clears tx_en, status_o[2] (transmit ready) and status_o[3] (transmitter empty). No other output changes.
- R6: Code 100 clears status_o[7:4], which are break, framing error, parity error and overrun from bit 7 down to bit 4. No other output changes.
- R7: cmd_data[3:2] controls the transmitter and cmd_data[1:0] controls the receiver. 01 enables, 10 disables, and 00 or 11 hold the state.
- R8: When a reset code and an enable for the same direction arrive in one write, the direction ends up disabled.
- R9: Codes 101, 110 and 111 in cmd_data[6:4] act as no command.
- R10: mode_acc moves mr_sel from 0 to 1 on the next cycle. mr_sel then stays at 1 until code 001 is written.
- R11: A high sts_set bit sets that status bit on the next cycle. A high sts_clr bit clears it, and a clear wins over a set. A command clear wins over both.
- R12: A miscellaneous command and both enable fields in one write all take effect on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_data | input | 8 | Command byte |
| mode_acc | input | 1 | A mode register access took place |
| sts_set | input | 8 | Per-bit status set events from the datapath |
| sts_clr | input | 8 | Per-bit status clear events from the datapath |
| rx_en | output | 1 | Receiver enabled |
| tx_en | output | 1 | Transmitter enabled |
| mr_sel | output | 1 | 0 selects mode register one, 1 selects mode register two |
| rx_ptr_init | output | 1 | One-cycle receive FIFO pointer reinitialise pulse |
| status_o | output | 8 | Channel status flags |

## Verification
Every result of this block is due exactly one clock edge after the cycle in which its strobe or event input was high. This covers enable changes, pointer moves, status clears and sets, and the pointer reinitialise pulse. Nothing takes effect combinationally, and nothing takes two edges. The bench drives inputs at the falling edge and lets the model and the design both take the next rising edge. It compares every output at the following falling edge, so each check lands on the cycle in which the result first becomes visible. Because the comparison runs on every cycle, an effect that arrives early, arrives late or lingers for a second cycle also shows up as a mismatch.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;

  localparam int CMD_W = 8;
  localparam int STS_W = 8;

  // miscellaneous command codes, field [6:4]
  localparam logic [2:0] MC_NONE   = 3'b000;
  localparam logic [2:0] MC_MRPTR  = 3'b001;
  localparam logic [2:0] MC_RXRST  = 3'b010;
  localparam logic [2:0] MC_TXRST  = 3'b011;
  localparam logic [2:0] MC_ERRRST = 3'b100;

  // two-bit enable field encoding
  localparam logic [1:0] EN_ON  = 2'b01;
  localparam logic [1:0] EN_OFF = 2'b10;

  // status bit positions
  localparam int ST_RXRDY = 0;
  localparam int ST_FFULL = 1;
  localparam int ST_TXRDY = 2;
  localparam int ST_TXEMT = 3;
  localparam int ST_OVR   = 4;
  localparam int ST_PAR   = 5;
  localparam int ST_FRM   = 6;
  localparam int ST_BRK   = 7;

  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;
  localparam int N_DIR  = 2;

  typedef struct packed {
    logic              mr_rst;
    logic [N_DIR-1:0]  dir_rst;
    logic [N_DIR-1:0]  dir_on;
    logic [N_DIR-1:0]  dir_off;
    logic [STS_W-1:0]  sts_wipe;
  } cmd_act_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_cmd_pkg::*;
(
  input  logic             we,
  input  logic [CMD_W-1:0] data,
  output cmd_act_t         act
);

  logic       unused_b7;
  logic [2:0] code;
  logic [1:0] fld [N_DIR];

  assign unused_b7    = data[7];
  assign code         = data[6:4];
  assign fld[DIR_RX]  = data[1:0];
  assign fld[DIR_TX]  = data[3:2];

  always_comb begin
    act = '0;
    if (we) begin
      for (int d = 0; d < N_DIR; d++) begin
        act.dir_on[d]  = (fld[d] == EN_ON);
        act.dir_off[d] = (fld[d] == EN_OFF);
      end
      case (code)
        MC_MRPTR: act.mr_rst = 1'b1;
        MC_RXRST: begin
          act.dir_rst[DIR_RX]     = 1'b1;
          act.sts_wipe[ST_RXRDY]  = 1'b1;
          act.sts_wipe[ST_FFULL]  = 1'b1;
        end
        MC_TXRST: begin
          act.dir_rst[DIR_TX]     = 1'b1;
          act.sts_wipe[ST_TXRDY]  = 1'b1;
          act.sts_wipe[ST_TXEMT]  = 1'b1;
        end
        MC_ERRRST: begin
          act.sts_wipe[ST_OVR] = 1'b1;
          act.sts_wipe[ST_PAR] = 1'b1;
          act.sts_wipe[ST_FRM] = 1'b1;
          act.sts_wipe[ST_BRK] = 1'b1;
        end
        default: act.mr_rst = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/uart_dir_enable.sv
module uart_dir_enable (
  input  logic clk,
  input  logic rst,
  input  logic on_i,
  input  logic off_i,
  input  logic reset_i,
  output logic en_q
);

  always_ff @(posedge clk) begin
    if (rst || reset_i) en_q <= 1'b0;
    else if (on_i)      en_q <= 1'b1;
    else if (off_i)     en_q <= 1'b0;
  end

endmodule

// File: rtl/uart_status_bank.sv
module uart_status_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] ev_set,
  input  logic [WIDTH-1:0] ev_clr,
  input  logic [WIDTH-1:0] cmd_wipe,
  output logic [WIDTH-1:0] flags_q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || cmd_wipe[i] || ev_clr[i]) flags_q[i] <= 1'b0;
      else if (ev_set[i])                  flags_q[i] <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_mode_ptr.sv
module uart_mode_ptr (
  input  logic clk,
  input  logic rst,
  input  logic access_i,
  input  logic rewind_i,
  output logic sel_q
);

  always_ff @(posedge clk) begin
    if (rst || rewind_i) sel_q <= 1'b0;
    else if (access_i)   sel_q <= 1'b1;
  end

endmodule

// File: rtl/uart_cmd_ctl.sv
module uart_cmd_ctl
  import uart_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             mode_acc,
  input  logic [STS_W-1:0] sts_set,
  input  logic [STS_W-1:0] sts_clr,
  output logic             rx_en,
  output logic             tx_en,
  output logic             mr_sel,
  output logic             rx_ptr_init,
  output logic [STS_W-1:0] status_o
);

  cmd_act_t         act;
  logic [N_DIR-1:0] en_q;

  uart_cmd_decode u_dec (
    .we   (cmd_we),
    .data (cmd_data),
    .act  (act)
  );

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    uart_dir_enable u_en (
      .clk     (clk),
      .rst     (rst),
      .on_i    (act.dir_on[d]),
      .off_i   (act.dir_off[d]),
      .reset_i (act.dir_rst[d]),
      .en_q    (en_q[d])
    );
  end

  assign rx_en = en_q[DIR_RX];
  assign tx_en = en_q[DIR_TX];

  uart_status_bank #(.WIDTH(STS_W)) u_sts (
    .clk      (clk),
    .rst      (rst),
    .ev_set   (sts_set),
    .ev_clr   (sts_clr),
    .cmd_wipe (act.sts_wipe),
    .flags_q  (status_o)
  );

  uart_mode_ptr u_mp (
    .clk      (clk),
    .rst      (rst),
    .access_i (mode_acc),
    .rewind_i (act.mr_rst),
    .sel_q    (mr_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) rx_ptr_init <= 1'b0;
    else     rx_ptr_init <= act.dir_rst[DIR_RX];
  end

endmodule

// File: rtl/uart_cmd_ctl_chk.sv
module uart_cmd_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_we,
  input logic [7:0] cmd_data,
  input logic       mode_acc,
  input logic [7:0] sts_set,
  input logic [7:0] sts_clr,
  input logic       rx_en,
  input logic       tx_en,
  input logic       mr_sel,
  input logic       rx_ptr_init,
  input logic [7:0] status_o
);

  logic [2:0] code;
  assign code = cmd_data[6:4];

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!rx_en && !tx_en && !mr_sel && !rx_ptr_init && status_o == 8'h00));

  a_r2_bit7_idle: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_data == 8'h80 && !mode_acc) |=> ($stable(rx_en) && $stable(tx_en) && $stable(mr_sel)));

  a_r3_mr_rewind: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && code == 3'b001) |=> !mr_sel);

  a_r4_rx_reset: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && code == 3'b010) |=> (!rx_en && status_o[1:0] == 2'b00 && rx_ptr_init));

  a_r4_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    !(cmd_we && code == 3'b010) |=> !rx_ptr_init);

  a_r5_tx_reset: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && code == 3'b011) |=> (!tx_en && status_o[3:2] == 2'b00));

  a_r6_err_reset: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && code == 3'b100) |=> status_o[7:4] == 4'h0);

  a_r7_rx_on: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_data[1:0] == 2'b01 && code != 3'b010) |=> rx_en);

  a_r7_tx_on: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_data[3:2] == 2'b01 && code != 3'b011) |=> tx_en);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_we |=> ($stable(rx_en) && $stable(tx_en)));

  a_r10_advance: assert property (@(posedge clk) disable iff (rst)
    (mode_acc && !(cmd_we && code == 3'b001)) |=> mr_sel);

  a_r11_set_bit0: assert property (@(posedge clk) disable iff (rst)
    (sts_set[0] && !sts_clr[0] && !(cmd_we && code == 3'b010)) |=> status_o[0]);

  a_r11_clr_bit7: assert property (@(posedge clk) disable iff (rst)
    sts_clr[7] |=> !status_o[7]);

endmodule

bind uart_cmd_ctl uart_cmd_ctl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_we      (cmd_we),
  .cmd_data    (cmd_data),
  .mode_acc    (mode_acc),
  .sts_set     (sts_set),
  .sts_clr     (sts_clr),
  .rx_en       (rx_en),
  .tx_en       (tx_en),
  .mr_sel      (mr_sel),
  .rx_ptr_init (rx_ptr_init),
  .status_o    (status_o)
);

// File: tb/uart_cmd_ctl_test.sv
`timescale 1ns/1ps
module uart_cmd_ctl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       mode_acc = 1'b0;
  logic [7:0] sts_set = 8'h00;
  logic [7:0] sts_clr = 8'h00;
  logic       rx_en, tx_en, mr_sel, rx_ptr_init;
  logic [7:0] status_o;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    done = 0;

  // behavioural reference state
  int m_rx = 0, m_tx = 0, m_mr = 0, m_pulse = 0;
  int m_sts = 0;

  always #10 clk = ~clk;

  uart_cmd_ctl uut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .mode_acc(mode_acc), .sts_set(sts_set), .sts_clr(sts_clr),
    .rx_en(rx_en), .tx_en(tx_en), .mr_sel(mr_sel),
    .rx_ptr_init(rx_ptr_init), .status_o(status_o)
  );

  always @(posedge clk) begin
    int c, rxf, txf;
    if (rst) begin
      m_rx = 0; m_tx = 0; m_mr = 0; m_pulse = 0; m_sts = 0;
    end else begin
      c   = cmd_we ? int'(cmd_data[6:4]) : 0;
      rxf = cmd_we ? int'(cmd_data[1:0]) : 0;
      txf = cmd_we ? int'(cmd_data[3:2]) : 0;
      m_sts = (m_sts | int'(sts_set)) & ~int'(sts_clr) & 255;
      if (rxf == 1) m_rx = 1; else if (rxf == 2) m_rx = 0;
      if (txf == 1) m_tx = 1; else if (txf == 2) m_tx = 0;
      if (mode_acc) m_mr = 1;
      m_pulse = 0;
      case (c)
        1: m_mr = 0;
        2: begin m_rx = 0; m_sts = m_sts & ~3; m_pulse = 1; end
        3: begin m_tx = 0; m_sts = m_sts & ~12; end
        4: m_sts = m_sts & 15;
        default: ;
      endcase
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp("rx_en", int'(rx_en), m_rx);
    cmp("tx_en", int'(tx_en), m_tx);
    cmp("mr_sel", int'(mr_sel), m_mr);
    cmp("rx_ptr_init", int'(rx_ptr_init), m_pulse);
    cmp("status_o", int'(status_o), m_sts);
  endtask

  task automatic wr(logic [7:0] d);
    cmd_we = 1'b1; cmd_data = d;
    tick();
    cmd_we = 1'b0; cmd_data = 8'h00;
  endtask

  task automatic ev(logic [7:0] s, logic [7:0] c);
    sts_set = s; sts_clr = c;
    tick();
    sts_set = 8'h00; sts_clr = 8'h00;
  endtask

  initial begin
    tag = "R1";
    tick(); tick();
    rst = 1'b0;
    tick();

    tag = "R7";
    wr(8'h05); tick();
    wr(8'h0F); tick();
    wr(8'h08); wr(8'h02); wr(8'h05);

    tag = "R2";
    wr(8'h80); wr(8'h8A); wr(8'h85);

    tag = "R11";
    ev(8'hFF, 8'h00);
    ev(8'h00, 8'h11);
    ev(8'h11, 8'h01);
    ev(8'hFF, 8'h00);

    tag = "R4";
    wr(8'h20); tick();
    ev(8'hFF, 8'h00); wr(8'h05);

    tag = "R5";
    wr(8'h30); tick();
    ev(8'hFF, 8'h00);

    tag = "R6";
    wr(8'h40); ev(8'hF0, 8'h00);

    tag = "R8";
    wr(8'h25); wr(8'h35); wr(8'h05);

    tag = "R9";
    ev(8'hFF, 8'h00);
    wr(8'h50); wr(8'h60); wr(8'h70); wr(8'hF0);

    tag = "R10";
    mode_acc = 1'b1; tick(); mode_acc = 1'b0;
    tick(); tick();
    wr(8'h00);

    tag = "R3";
    wr(8'h10); tick();
    mode_acc = 1'b1; tick();
    cmd_we = 1'b1; cmd_data = 8'h10; tick();
    cmd_we = 1'b0; mode_acc = 1'b0; tick();

    tag = "R12";
    wr(8'h0A); ev(8'hFF, 8'h00);
    wr(8'h45); wr(8'h3A); wr(8'h25);

    tag = "R11";
    cmd_we = 1'b1; cmd_data = 8'h20; sts_set = 8'hFF; tick();
    cmd_we = 1'b0; sts_set = 8'h00; tick();

    tag = "R1";
    rst = 1'b1; tick(); rst = 1'b0; tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule